// File: doc/BRIEF.md
# Core-local timer and software interrupt unit

This unit sits beside a single processor core and raises its two machine-level interrupt lines. It holds a 64-bit time counter, a 64-bit compare value and a one-bit software interrupt flag. The counter runs all the time and steps forward by one after every `TICK_COUNT` clocks. The timer interrupt line is high while the counter is at or above the compare value. The software interrupt line follows the flag directly. The current count is also driven on a dedicated output, so the core can use it as a shadow copy of its time counter.

Software reaches the three registers through a 64-bit AXI4-Lite slave port with byte strobes. Address bits [15:3] select an 8-byte word, and strobe lane i carries data bits [8i+7:8i]. Words are at these offsets: the flag at 0x0000, the compare value at 0x4000 and the counter at 0xBFF8. Any other offset gets an error response. A write to the counter replaces the running count and restarts the prescaler. A write to the compare value drops the timer line for one cycle, and the line is then evaluated again.

Top module: `core_timer_irq`

## Requirements
- R1: After reset the counter, the compare value and the flag are zero: `time_now` is 0, `sw_irq` is 0, and the compare word reads 0.
- R2: With no counter write, `time_now` increases by exactly 1 every `TICK_COUNT` clocks.
- R3: `tmr_irq` is a registered copy of (counter >= compare) using an unsigned 64-bit comparison. It follows a change of either operand by one clock.
- R4: A write with any strobe to the compare word forces `tmr_irq` low in the cycle after the write commits. One cycle later the line shows the comparison with the new value.
- R5: Bit 0 of byte lane 0 at offset 0x0000 is the flag, and it drives `sw_irq`. All other bits of that word read as 0 and ignore writes.
- R6: Writes update only the byte lanes whose `s_wstrb` bit is set, and the other bytes keep their value. Address bits [2:0] do not take part in decoding.
- R7: A counter write puts the written bytes into the count at once and restarts the prescaler. The next increment comes `TICK_COUNT` clocks after the write commits, and a read returns the written value.
- R8: When a counter write commits in the same cycle as a prescaler tick, the written value is kept and that tick's increment is lost.
- R9: Accesses to mapped words respond OKAY (2'b00). An access to any other offset responds SLVERR (2'b10), reads return 0, and writes change no register.
- R10: The write address and the write data are accepted independently and held until both are present. Each direction has at most one transaction in flight. A response stays valid until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 16 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 64 | Write data |
| s_wstrb | input | 8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response (00 OKAY, 10 SLVERR) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 16 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 64 | Read data |
| s_rresp | output | 2 | Read response (00 OKAY, 10 SLVERR) |
| sw_irq | output | 1 | Software interrupt pending |
| tmr_irq | output | 1 | Timer interrupt pending |
| time_now | output | 64 | Current counter value |

## Verification
A bad count value shows on `time_now` in the same cycle, and a wrong prescaler phase shows up at the next expected step, at most `TICK_COUNT` clocks later. If the compare value is corrupted or a strobe goes to the wrong lane, `tmr_irq` has the wrong level one clock after the counter crosses the threshold, and a readback of the word gives a different value. A write that reaches the wrong register, or an unmapped write that has an effect, appears in the next readback or on the interrupt lines. Each write test is placed at a known prescaler phase, so that a lost or extra tick can be seen within one tick period.

// File: rtl/ctirq_pkg.sv
package ctirq_pkg;

  localparam int CT_ADDR_W = 16;
  localparam int CT_DATA_W = 64;
  localparam int CT_STRB_W = CT_DATA_W / 8;

  localparam logic [CT_ADDR_W-1:0] SWI_OFS  = 16'h0000;
  localparam logic [CT_ADDR_W-1:0] CMP_OFS  = 16'h4000;
  localparam logic [CT_ADDR_W-1:0] TIME_OFS = 16'hBFF8;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SWI  = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_TIME = 2'd3
  } sel_e;

  // word select from the upper address bits; byte offset bits are ignored
  function automatic sel_e decode_addr(input logic [CT_ADDR_W-1:0] a);
    sel_e s;
    if (a[CT_ADDR_W-1:3] == SWI_OFS[CT_ADDR_W-1:3])       s = SEL_SWI;
    else if (a[CT_ADDR_W-1:3] == CMP_OFS[CT_ADDR_W-1:3])  s = SEL_CMP;
    else if (a[CT_ADDR_W-1:3] == TIME_OFS[CT_ADDR_W-1:3]) s = SEL_TIME;
    else                                                  s = SEL_NONE;
    return s;
  endfunction

  function automatic logic [CT_DATA_W-1:0] merge_bytes(
    input logic [CT_DATA_W-1:0] old_v,
    input logic [CT_DATA_W-1:0] new_v,
    input logic [CT_STRB_W-1:0] strb
  );
    logic [CT_DATA_W-1:0] r;
    r = old_v;
    for (int i = 0; i < CT_STRB_W; i++) begin
      if (strb[i]) r[8*i +: 8] = new_v[8*i +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/ctirq_prescale.sv
module ctirq_prescale #(
  parameter int TICK_COUNT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_COUNT > 2) ? $clog2(TICK_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_COUNT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (tick_o) cnt_d = '0;
    if (clr_i)  cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a tick is a single-cycle pulse
  p_tick_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R7: a restart leaves a full period before the next tick
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !tick_o);

endmodule

// File: rtl/ctirq_axil_slv.sv
module ctirq_axil_slv
  import ctirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [CT_ADDR_W-1:0] s_awaddr,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  input  logic [CT_DATA_W-1:0] s_wdata,
  input  logic [CT_STRB_W-1:0] s_wstrb,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  output logic [1:0]           s_bresp,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  input  logic [CT_ADDR_W-1:0] s_araddr,
  output logic                 s_rvalid,
  input  logic                 s_rready,
  output logic [CT_DATA_W-1:0] s_rdata,
  output logic [1:0]           s_rresp,
  output logic                 wr_en_o,
  output logic [CT_ADDR_W-1:0] wr_addr_o,
  output logic [CT_DATA_W-1:0] wr_data_o,
  output logic [CT_STRB_W-1:0] wr_strb_o,
  input  logic                 wr_err_i,
  output logic [CT_ADDR_W-1:0] rd_addr_o,
  input  logic [CT_DATA_W-1:0] rd_data_i,
  input  logic                 rd_err_i
);
  logic                 aw_full_q, aw_full_d;
  logic [CT_ADDR_W-1:0] aw_addr_q;
  logic                 w_full_q, w_full_d;
  logic [CT_DATA_W-1:0] w_data_q;
  logic [CT_STRB_W-1:0] w_strb_q;
  logic                 bvalid_q, bvalid_d;
  logic [1:0]           bresp_q;
  logic                 rvalid_q, rvalid_d;
  logic [CT_DATA_W-1:0] rdata_q;
  logic [1:0]           rresp_q;
  logic                 aw_take, w_take, wr_fire, rd_fire;

  assign s_awready = !aw_full_q;
  assign s_wready  = !w_full_q;
  assign s_arready = !rvalid_q;
  assign aw_take   = s_awvalid && s_awready;
  assign w_take    = s_wvalid && s_wready;
  assign wr_fire   = aw_full_q && w_full_q && !bvalid_q;
  assign rd_fire   = s_arvalid && s_arready;

  assign wr_en_o   = wr_fire;
  assign wr_addr_o = aw_addr_q;
  assign wr_data_o = w_data_q;
  assign wr_strb_o = w_strb_q;
  assign rd_addr_o = s_araddr;

  assign s_bvalid = bvalid_q;
  assign s_bresp  = bresp_q;
  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_rresp  = rresp_q;

  always_comb begin
    aw_full_d = aw_full_q;
    if (aw_take) aw_full_d = 1'b1;
    if (wr_fire) aw_full_d = 1'b0;
    w_full_d = w_full_q;
    if (w_take)  w_full_d = 1'b1;
    if (wr_fire) w_full_d = 1'b0;
    bvalid_d = bvalid_q;
    if (bvalid_q && s_bready) bvalid_d = 1'b0;
    if (wr_fire)              bvalid_d = 1'b1;
    rvalid_d = rvalid_q;
    if (rvalid_q && s_rready) rvalid_d = 1'b0;
    if (rd_fire)              rvalid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      rvalid_q  <= 1'b0;
    end else begin
      aw_full_q <= aw_full_d;
      w_full_q  <= w_full_d;
      bvalid_q  <= bvalid_d;
      rvalid_q  <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aw_addr_q <= '0;
    else if (aw_take) aw_addr_q <= s_awaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_data_q <= '0;
      w_strb_q <= '0;
    end else if (w_take) begin
      w_data_q <= s_wdata;
      w_strb_q <= s_wstrb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bresp_q <= RESP_OKAY;
    else if (wr_fire) bresp_q <= wr_err_i ? RESP_SLVERR : RESP_OKAY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rresp_q <= RESP_OKAY;
    end else if (rd_fire) begin
      rdata_q <= rd_err_i ? '0 : rd_data_i;
      rresp_q <= rd_err_i ? RESP_SLVERR : RESP_OKAY;
    end
  end

  // R10: a pending write response is held until taken
  p_bresp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));

  // R10: a pending read response is held until taken
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  // R9: an error read carries no data
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && (s_rresp == RESP_SLVERR) |-> s_rdata == '0);

endmodule

// File: rtl/ctirq_regs.sv
module ctirq_regs
  import ctirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [CT_ADDR_W-1:0] wr_addr_i,
  input  logic [CT_DATA_W-1:0] wr_data_i,
  input  logic [CT_STRB_W-1:0] wr_strb_i,
  output logic                 wr_err_o,
  input  logic [CT_ADDR_W-1:0] rd_addr_i,
  output logic [CT_DATA_W-1:0] rd_data_o,
  output logic                 rd_err_o,
  input  logic                 tick_i,
  output logic                 time_wr_o,
  output logic [CT_DATA_W-1:0] time_o,
  output logic                 tmr_irq_o,
  output logic                 sw_irq_o
);
  logic                 sw_q, sw_d;
  logic [CT_DATA_W-1:0] cmp_q, cmp_d;
  logic [CT_DATA_W-1:0] time_q, time_d;
  logic                 tmr_q, tmr_d;
  sel_e                 wsel, rsel;
  logic                 wr_swi, wr_cmp, wr_time;

  assign wsel    = decode_addr(wr_addr_i);
  assign rsel    = decode_addr(rd_addr_i);
  assign wr_swi  = wr_en_i && (wsel == SEL_SWI);
  assign wr_cmp  = wr_en_i && (wsel == SEL_CMP);
  assign wr_time = wr_en_i && (wsel == SEL_TIME);
  assign wr_err_o = (wsel == SEL_NONE);
  assign rd_err_o = (rsel == SEL_NONE);

  assign time_wr_o = wr_time;
  assign time_o    = time_q;
  assign tmr_irq_o = tmr_q;
  assign sw_irq_o  = sw_q;

  always_comb begin
    sw_d = sw_q;
    if (wr_swi && wr_strb_i[0]) sw_d = wr_data_i[0];
    cmp_d = cmp_q;
    if (wr_cmp) cmp_d = merge_bytes(cmp_q, wr_data_i, wr_strb_i);
    time_d = time_q;
    if (tick_i)  time_d = time_q + 64'd1;
    if (wr_time) time_d = merge_bytes(time_q, wr_data_i, wr_strb_i);
    tmr_d = (time_q >= cmp_q);
    if (wr_cmp) tmr_d = 1'b0;
  end

  always_comb begin
    case (rsel)
      SEL_SWI:  rd_data_o = {{(CT_DATA_W-1){1'b0}}, sw_q};
      SEL_CMP:  rd_data_o = cmp_q;
      SEL_TIME: rd_data_o = time_q;
      default:  rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= 1'b0;
      cmp_q  <= '0;
      time_q <= '0;
      tmr_q  <= 1'b0;
    end else begin
      sw_q   <= sw_d;
      cmp_q  <= cmp_d;
      time_q <= time_d;
      tmr_q  <= tmr_d;
    end
  end

  // R4: a compare write drops the timer line in the next cycle
  p_tmr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> !tmr_irq_o);

  // R2: without a tick or a counter write the count holds
  p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !wr_time |=> $stable(time_o));

  // R5: the flag moves only on a strobed lane-0 write
  p_sw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_swi && wr_strb_i[0]) |=> $stable(sw_irq_o));

  // R9: an unmapped write leaves the compare value alone
  p_err_noeff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_err_o |=> $stable(cmp_q));

endmodule

// File: rtl/core_timer_irq.sv
module core_timer_irq
  import ctirq_pkg::*;
#(
  parameter int TICK_COUNT = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [CT_ADDR_W-1:0] s_awaddr,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  input  logic [CT_DATA_W-1:0] s_wdata,
  input  logic [CT_STRB_W-1:0] s_wstrb,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  output logic [1:0]           s_bresp,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  input  logic [CT_ADDR_W-1:0] s_araddr,
  output logic                 s_rvalid,
  input  logic                 s_rready,
  output logic [CT_DATA_W-1:0] s_rdata,
  output logic [1:0]           s_rresp,
  output logic                 sw_irq,
  output logic                 tmr_irq,
  output logic [CT_DATA_W-1:0] time_now
);
  logic [1:0]           rst_pipe_q;
  logic                 rst_int_n;
  logic                 wr_en, wr_err, rd_err, tick, time_wr;
  logic [CT_ADDR_W-1:0] wr_addr, rd_addr;
  logic [CT_DATA_W-1:0] wr_data, rd_data;
  logic [CT_STRB_W-1:0] wr_strb;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  ctirq_axil_slv u_bus (
    .clk(clk), .rst_n(rst_int_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb),
    .wr_err_i(wr_err), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_err_i(rd_err)
  );

  ctirq_prescale #(.TICK_COUNT(TICK_COUNT)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .clr_i(time_wr), .tick_o(tick)
  );

  ctirq_regs u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .wr_err_o(wr_err), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_err_o(rd_err),
    .tick_i(tick), .time_wr_o(time_wr), .time_o(time_now),
    .tmr_irq_o(tmr_irq), .sw_irq_o(sw_irq)
  );

  initial begin
    assert (TICK_COUNT > 1) else $error("TICK_COUNT must exceed 1");
  end

endmodule

// File: tb/sim_core_timer_irq.sv
`timescale 1ns/1ps
module sim_core_timer_irq;
  localparam int TICK = 4;
  localparam logic [1:0] OKAY = 2'b00;
  localparam logic [1:0] SERR = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        awvalid, awready, wvalid, wready, bvalid, bready;
  logic        arvalid, arready, rvalid, rready;
  logic [15:0] awaddr, araddr;
  logic [63:0] wdata, rdata, time_now;
  logic [7:0]  wstrb;
  logic [1:0]  bresp, rresp;
  logic        sw_irq, tmr_irq;

  int nchk = 0;
  int nfail = 0;
  int cycles = 0;
  bit done = 0;

  logic [63:0] rq_data[$];
  logic [1:0]  rq_resp[$];
  string       rq_tag[$];
  logic [1:0]  bq_resp[$];
  string       bq_tag[$];

  always #2.5 clk = ~clk;

  core_timer_irq #(.TICK_COUNT(TICK)) u0 (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .sw_irq(sw_irq), .tmr_irq(tmr_irq), .time_now(time_now)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (rq_data.size() == 0) chk("R10 unexpected read response", 64'd1, 64'd0);
      else begin
        string t;
        t = rq_tag.pop_front();
        chk({t, " rdata"}, rdata, rq_data.pop_front());
        chk({t, " rresp"}, {62'd0, rresp}, {62'd0, rq_resp.pop_front()});
      end
    end
    if (rst_n && bvalid) begin
      if (bq_resp.size() == 0) chk("R10 unexpected write response", 64'd1, 64'd0);
      else begin
        string t;
        t = bq_tag.pop_front();
        chk({t, " bresp"}, {62'd0, bresp}, {62'd0, bq_resp.pop_front()});
      end
    end
  end

  // called at a negedge; returns at the negedge after the write commits
  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic [7:0] s,
                    input logic [1:0] er, input int gap, input string tag);
    bq_resp.push_back(er);
    bq_tag.push_back(tag);
    awaddr = a; awvalid = 1'b1;
    wdata = d; wstrb = s;
    if (gap > 0) begin
      @(negedge clk);
      awvalid = 1'b0;
      repeat (gap) @(negedge clk);
      chk("R10 no response before data", {63'd0, bvalid}, 64'd0);
    end
    wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    while (!bvalid) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [63:0] ed, input logic [1:0] er,
                    input string tag);
    @(negedge clk);
    rq_data.push_back(ed);
    rq_resp.push_back(er);
    rq_tag.push_back(tag);
    araddr = a; arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      nchk++; nfail++;
      $display("FAIL R10 watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    awvalid = 0; wvalid = 0; arvalid = 0;
    awaddr = '0; araddr = '0; wdata = '0; wstrb = '0;
    bready = 1'b1; rready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 time after reset", time_now, 64'd0);
    chk("R1 sw_irq after reset", {63'd0, sw_irq}, 64'd0);
    chk("R3 tmr_irq with 0>=0", {63'd0, tmr_irq}, 64'd1);
    rd(16'h4000, 64'd0, OKAY, "R1 compare reads zero");
    rd(16'h0000, 64'd0, OKAY, "R1 flag reads zero");

    // R4/R3 compare write
    wr(16'h4000, 64'd100, 8'hFF, OKAY, 0, "R9 okay on compare");
    chk("R4 cleared after compare write", {63'd0, tmr_irq}, 64'd0);
    repeat (2) @(negedge clk);
    chk("R3 low below compare", {63'd0, tmr_irq}, 64'd0);

    // R7/R2 counter write and prescaler restart
    wr(16'hBFF8, 64'd99, 8'hFF, OKAY, 0, "R9 okay on counter");
    chk("R7 written count visible", time_now, 64'd99);
    repeat (3) @(negedge clk);
    chk("R7 no step before full period", time_now, 64'd99);
    @(negedge clk);
    chk("R2 step after period", time_now, 64'd100);
    chk("R3 one-cycle lag", {63'd0, tmr_irq}, 64'd0);
    @(negedge clk);
    chk("R3 high at equality", {63'd0, tmr_irq}, 64'd1);
    repeat (3) @(negedge clk);
    chk("R2 second step", time_now, 64'd101);

    // R4 clear then re-evaluate while condition still true
    wr(16'h4000, 64'd0, 8'h02, OKAY, 0, "R6 okay lane1 compare");
    chk("R4 forced low", {63'd0, tmr_irq}, 64'd0);
    @(negedge clk);
    chk("R4 re-evaluated high", {63'd0, tmr_irq}, 64'd1);

    // R8 write collides with tick
    wr(16'hBFF8, 64'd1000, 8'hFF, OKAY, 0, "R8 first write");
    repeat (2) @(negedge clk);
    wr(16'hBFF8, 64'd2000, 8'hFF, OKAY, 0, "R8 second write");
    chk("R8 write wins over tick", time_now, 64'd2000);
    repeat (3) @(negedge clk);
    chk("R8 tick dropped", time_now, 64'd2000);
    @(negedge clk);
    chk("R8 next step full period later", time_now, 64'd2001);

    // R6 byte lanes
    wr(16'h4000, 64'h1122334455667788, 8'hFF, OKAY, 0, "R6 full write");
    wr(16'h4004, 64'hAABBCCDDEEFF0099, 8'h30, OKAY, 0, "R6 partial write");
    rd(16'h4000, 64'h1122CCDD55667788, OKAY, "R6 merged bytes");
    chk("R3 low below large compare", {63'd0, tmr_irq}, 64'd0);

    // R3 unsigned compare
    wr(16'hBFF8, 64'hFFFF_FFFF_FFFF_FF00, 8'hFF, OKAY, 0, "R3 big count");
    wr(16'h4000, 64'd5, 8'hFF, OKAY, 0, "R3 small compare");
    @(negedge clk);
    chk("R3 unsigned high", {63'd0, tmr_irq}, 64'd1);

    // R7 readback
    wr(16'hBFF8, 64'h0123456789ABCDEF, 8'hFF, OKAY, 0, "R7 write count");
    rd(16'hBFF8, 64'h0123456789ABCDEF, OKAY, "R7 readback");

    // R5 flag
    wr(16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, OKAY, 0, "R5 set flag");
    chk("R5 sw_irq set", {63'd0, sw_irq}, 64'd1);
    rd(16'h0000, 64'd1, OKAY, "R5 upper bits zero");
    wr(16'h0000, 64'd0, 8'hFE, OKAY, 0, "R6 lane0 unstrobed");
    chk("R6 flag kept without lane0 strobe", {63'd0, sw_irq}, 64'd1);
    wr(16'h0003, 64'd0, 8'h01, OKAY, 0, "R6 low bits ignored");
    chk("R5 sw_irq cleared", {63'd0, sw_irq}, 64'd0);

    // R9 unmapped
    wr(16'h4008, 64'hDEAD, 8'hFF, SERR, 0, "R9 unmapped write");
    rd(16'h4000, 64'd5, OKAY, "R9 unmapped write no effect");
    rd(16'hBFF0, 64'd0, SERR, "R9 unmapped read");
    wr(16'h0008, 64'd1, 8'hFF, SERR, 0, "R9 unmapped near flag");
    chk("R9 flag untouched", {63'd0, sw_irq}, 64'd0);

    // R10 address before data
    wr(16'h4000, 64'd77, 8'hFF, OKAY, 3, "R10 split write");
    rd(16'h4000, 64'd77, OKAY, "R10 split write data");

    repeat (4) @(negedge clk);
    chk("R10 all responses seen", 64'(rq_data.size() + bq_resp.size()), 64'd0);
    finish_run();
  end

endmodule